// File: doc/BRIEF.md
# Synchronized Dual-Accumulator Ratio Counter

This block is the counting core of a ratio-style frequency and period counter. Accumulator A always counts rising edges of the conditioned channel A signal. Accumulator B counts rising edges of either the internal timebase or the conditioned channel B signal, depending on a source-select bit. A host opens and closes the measurement with a gate level that has no timing relation to any counted signal. That gate is ANDed with an external arm input.

The qualified gate reaches each accumulator through its own two-flop synchronizer, which is clocked by the signal that accumulator counts. Each count window therefore opens and closes on that signal's own edges, and the host always reads whole pulses. The host divides the two counts itself.

The path enables and the B source select are loaded serially and applied as one group by a latch strobe. A synchronous clear prepares both accumulators for a new measurement. A done flag tells the host when both windows have closed.

Top module: `ratio_counter_core`

## Requirements
- R1: While reset is asserted, and after it is released with the gate low, both counts read 0, both overflow flags read 0, `done` reads 1, and all three control bits are 0.
- R2: With bit 0 (channel A path enable) set, `count_a` after a measurement equals the number of `chan_a` rising edges that occur while `meas_gate` and `arm` are both high.
- R3: With bit 1 (channel B path enable) set, `count_b` counts `tbase_clk` rising edges when bit 2 is 0. It counts `chan_b` rising edges when bit 2 is 1. In both cases only edges inside the gated interval are counted.
- R4: Each accumulator's enable is the gate delayed through `SYNC_STAGES` flops clocked by that accumulator's own counted clock, so the enable changes only on that clock's rising edges. The count is always an exact integer, even though the gate edges are asynchronous.
- R5: A `clr` level seen at a counted clock's rising edge zeroes that accumulator and its overflow flag.
- R6: When an accumulator advances from all ones, it wraps to 0 and sets its overflow flag. The flag stays set until a clear.
- R7: With `arm` low, neither accumulator advances, whatever `meas_gate` does.
- R8: While `ser_le` is low, each `ser_clk` rising edge shifts `ser_din` into bit 0 and moves the other bits toward bit 2. A `ser_clk` rising edge with `ser_le` high copies the shift register into the applied control bits. The bits are: bit 0 enables the channel A path, bit 1 enables the channel B path, and bit 2 selects channel B (1) or the timebase (0) for accumulator B.
- R9: Shifting new bits without a latch strobe leaves the applied control bits, and therefore the counting behaviour, unchanged.
- R10: `done` is high exactly when the qualified gate (`meas_gate` AND `arm`) is low and both synchronized enables are low. It is low during an armed measurement.
- R11: An accumulator whose path-enable bit is 0 stays at 0 through a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| chan_a | input | 1 | Conditioned channel A signal, counted by accumulator A |
| chan_b | input | 1 | Conditioned channel B signal |
| tbase_clk | input | 1 | Internal timebase clock |
| meas_gate | input | 1 | Host measurement gate, asynchronous |
| arm | input | 1 | External arm level, ANDed with the gate |
| clr | input | 1 | Synchronous clear of both accumulators and their flags |
| ser_clk | input | 1 | Serial control shift clock |
| ser_din | input | 1 | Serial control data |
| ser_le | input | 1 | Latch strobe; applies the shifted bits on a ser_clk edge |
| count_a | output | ACC_W | Accumulator A value |
| count_b | output | ACC_W | Accumulator B value |
| ovf_a | output | 1 | Sticky overflow of accumulator A |
| ovf_b | output | 1 | Sticky overflow of accumulator B |
| done | output | 1 | Both count windows closed and gate low |

## Verification
Channel A, channel B and the timebase run at mutually unrelated periods. The gate toggles at offsets that never coincide with any counted edge. The expected counts come from the bench's own edge tallies taken while the gate is open. Table rows vary the gate length, the arm level, the path enables and the B source. This separates a correct whole-pulse window from an off-by-one, from a wrong source selection, and from an arm or enable that is ignored. Directed runs cover a short gate, a gate long enough to wrap the accumulator, clear-after-overflow, and shifting without a latch.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;

    // Applied control bits; bit order is the serial load order (bit 2 shifted first)
    typedef struct packed {
        logic b_src_chb;   // bit 2: accumulator B counts channel B (1) or timebase (0)
        logic b_path_en;   // bit 1: channel B path enable
        logic a_path_en;   // bit 0: channel A path enable
    } rcc_ctrl_t;

    localparam int unsigned CTRL_W = $bits(rcc_ctrl_t);

endpackage

// File: rtl/rcc_ctrl_shift.sv
`timescale 1ns/1ps
module rcc_ctrl_shift
    import rcc_pkg::*;
(
    input  logic      ser_clk,
    input  logic      rst_n,
    input  logic      ser_din,
    input  logic      ser_le,
    output rcc_ctrl_t ctrl
);

    typedef struct packed {
        logic [CTRL_W-1:0] shreg;
        rcc_ctrl_t         hold;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ser_le) begin
            st_d.hold = rcc_ctrl_t'(st_q.shreg);
        end else begin
            st_d.shreg = {st_q.shreg[CTRL_W-2:0], ser_din};
        end
    end

    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.hold;

    // R9: applied bits only move on a strobed edge
    a_r9_hold_without_strobe: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !ser_le |=> $stable(ctrl));

endmodule

// File: rtl/rcc_gate_sync.sv
`timescale 1ns/1ps
module rcc_gate_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic sig_clk,
    input  logic rst_n,
    input  logic gate_in,
    output logic en
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("rcc_gate_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], gate_in};
    end

    always_ff @(posedge sig_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en = st_q.chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R4: window opens/closes two own-clock edges after the gate was sampled
            a_r4_open_follows_gate: assert property (@(posedge sig_clk) disable iff (!rst_n)
                $rose(en) |-> $past(gate_in, 2));
            a_r4_close_follows_gate: assert property (@(posedge sig_clk) disable iff (!rst_n)
                $fell(en) |-> !$past(gate_in, 2));
        end
    endgenerate

endmodule

// File: rtl/rcc_accum.sv
`timescale 1ns/1ps
module rcc_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             cnt_clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [ACC_W-1:0] count,
    output logic             ovf
);

    typedef struct packed {
        logic [ACC_W-1:0] cnt;
        logic             ovf;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else if (en) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.ovf = st_q.ovf | (&st_q.cnt);
        end
    end

    always_ff @(posedge cnt_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

    // R5: clear empties count and flag on the next own-clock edge
    a_r5_clear_zeroes: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        clr |=> (count == '0) && !ovf);
    // R6: flag is sticky until clear
    a_r6_ovf_sticky: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
    // R2: one step per enabled edge, none otherwise
    a_r2_step_one: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (en && !clr) |=> count == ACC_W'($past(count) + 1'b1));
    a_r2_hold_idle: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count));

endmodule

// File: rtl/ratio_counter_core.sv
`timescale 1ns/1ps
module ratio_counter_core #(
    parameter int unsigned ACC_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             rst_n,
    input  logic             chan_a,
    input  logic             chan_b,
    input  logic             tbase_clk,
    input  logic             meas_gate,
    input  logic             arm,
    input  logic             clr,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             ser_le,
    output logic [ACC_W-1:0] count_a,
    output logic [ACC_W-1:0] count_b,
    output logic             ovf_a,
    output logic             ovf_b,
    output logic             done
);

    import rcc_pkg::*;

    rcc_ctrl_t ctrl;
    logic      gate_q;     // qualified host gate
    logic      gate_a;
    logic      gate_b;
    logic      clk_b;
    logic      en_a;
    logic      en_b;

    rcc_ctrl_shift i_ctrl (
        .ser_clk (ser_clk),
        .rst_n   (rst_n),
        .ser_din (ser_din),
        .ser_le  (ser_le),
        .ctrl    (ctrl)
    );

    always_comb begin
        gate_q = meas_gate & arm;
        gate_a = gate_q & ctrl.a_path_en;
        gate_b = gate_q & ctrl.b_path_en;
        clk_b  = ctrl.b_src_chb ? chan_b : tbase_clk;
        done   = ~gate_q & ~en_a & ~en_b;
    end

    rcc_gate_sync #(.STAGES(SYNC_STAGES)) i_sync_a (
        .sig_clk (chan_a),
        .rst_n   (rst_n),
        .gate_in (gate_a),
        .en      (en_a)
    );

    rcc_gate_sync #(.STAGES(SYNC_STAGES)) i_sync_b (
        .sig_clk (clk_b),
        .rst_n   (rst_n),
        .gate_in (gate_b),
        .en      (en_b)
    );

    rcc_accum #(.ACC_W(ACC_W)) i_acc_a (
        .cnt_clk (chan_a),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (en_a),
        .count   (count_a),
        .ovf     (ovf_a)
    );

    rcc_accum #(.ACC_W(ACC_W)) i_acc_b (
        .cnt_clk (clk_b),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (en_b),
        .count   (count_b),
        .ovf     (ovf_b)
    );

endmodule

// File: tb/test_ratio_counter_core.sv
`timescale 1ns/1ps
module test_ratio_counter_core;

    localparam int unsigned ACC_W = 10;
    localparam longint      WRAP  = 64'd1 << ACC_W;

    logic clk = 0, cha = 0, chb = 0;
    logic rst_n = 0, gate = 0, arm = 0, clr = 0;
    logic sclk = 0, sdin = 0, sle = 0;
    logic [ACC_W-1:0] count_a, count_b;
    logic ovf_a, ovf_b, done;

    int n_chk = 0, n_fail = 0;
    int m_a = 0, m_b = 0;
    logic [2:0] m_ctrl = 3'b000;

    always #10   clk = ~clk;   // 50 MHz, also the timebase
    always #6.85 cha = ~cha;
    always #4.55 chb = ~chb;

    ratio_counter_core #(.ACC_W(ACC_W)) i_ratio_counter_core (
        .rst_n(rst_n), .chan_a(cha), .chan_b(chb), .tbase_clk(clk),
        .meas_gate(gate), .arm(arm), .clr(clr),
        .ser_clk(sclk), .ser_din(sdin), .ser_le(sle),
        .count_a(count_a), .count_b(count_b), .ovf_a(ovf_a), .ovf_b(ovf_b), .done(done)
    );

    // Independent tallies of edges inside the armed gate
    always @(posedge cha) if (gate && arm && m_ctrl[0]) m_a++;
    always @(posedge clk) if (gate && arm && m_ctrl[1] && !m_ctrl[2]) m_b++;
    always @(posedge chb) if (gate && arm && m_ctrl[1] && m_ctrl[2]) m_b++;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;   // move to a point away from every counted edge
        @(posedge clk);
        #3.025;
    endtask

    task automatic load_ctrl(input logic [2:0] w, input bit strobe);
        for (int i = 2; i >= 0; i--) begin
            sdin = w[i];
            #5 sclk = 1;
            #5 sclk = 0;
        end
        if (strobe) begin
            sle = 1;
            #5 sclk = 1;
            #5 sclk = 0;
            sle = 0;
            m_ctrl = w;
        end
    endtask

    task automatic do_clear;
        tick;
        clr = 1;
        repeat (8) tick;
        clr = 0;
        m_a = 0;
        m_b = 0;
    endtask

    task automatic measure(input int len, input string tag);
        do_clear;
        tick;
        gate = 1;
        repeat (3) tick;
        chk({tag, " R10 done during gate"}, done, !arm);
        repeat (len - 3) tick;
        gate = 0;
        repeat (10) tick;
        chk({tag, " R10 done after close"}, done, 1);
    endtask

    // len[19:4], arm[3], ctrl[2:0]
    localparam int NV = 6;
    localparam logic [19:0] VEC [NV] = '{
        {16'd40, 1'b1, 3'b011},   // R2 R3 timebase source
        {16'd57, 1'b1, 3'b111},   // R3 channel B source
        {16'd33, 1'b0, 3'b111},   // R7 disarmed
        {16'd25, 1'b1, 3'b010},   // R11 A path off
        {16'd61, 1'b1, 3'b001},   // R11 B path off
        {16'd3,  1'b1, 3'b111}    // R4 short gate
    };

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #3.025;
        chk("R1 reset count_a", count_a, 0);
        chk("R1 reset ovf_a", ovf_a, 0);
        chk("R1 reset done", done, 1);
        rst_n = 1;
        repeat (4) tick;
        chk("R1 after reset count_b", count_b, 0);
        chk("R1 after reset ovf_b", ovf_b, 0);
        // Control bits reset to 0: an armed gate counts nothing
        arm = 1;
        measure(20, "R1 ctrl");
        chk("R1 ctrl reset count_a", count_a, 0);
        chk("R1 ctrl reset count_b", count_b, 0);

        for (int v = 0; v < NV; v++) begin
            load_ctrl(VEC[v][2:0], 1);
            arm = VEC[v][3];
            measure(int'(VEC[v][19:4]), "vec");
            chk("R2 R4 count_a exact", count_a, m_a % WRAP);
            chk("R3 R8 count_b exact", count_b, m_b % WRAP);
            if (!arm) begin
                chk("R7 no A count disarmed", count_a, 0);
                chk("R7 no B count disarmed", count_b, 0);
            end
            if (!VEC[v][0]) chk("R11 A path off", count_a, 0);
            if (!VEC[v][1]) chk("R11 B path off", count_b, 0);
        end

        // R9: shift a different word without strobe; old settings remain
        arm = 1;
        load_ctrl(3'b011, 1);
        load_ctrl(3'b100, 0);
        measure(30, "R9");
        chk("R9 count_a unchanged setup", count_a, m_a % WRAP);
        chk("R9 count_b still timebase", count_b, m_b % WRAP);
        chk("R9 timebase gate count", (count_b >= 29 && count_b <= 31), 1);

        // R6: long gate wraps accumulator A
        measure(800, "R6");
        chk("R6 count_a wrapped", count_a, m_a % WRAP);
        chk("R6 ovf_a set", ovf_a, (m_a >= WRAP));
        chk("R6 ovf_b clear", ovf_b, 0);
        repeat (20) tick;
        chk("R6 ovf_a sticky", ovf_a, 1);

        // R5: clear empties counts and flags
        do_clear;
        chk("R5 clear count_a", count_a, 0);
        chk("R5 clear ovf_a", ovf_a, 0);
        chk("R5 clear count_b", count_b, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule